// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a bus target for a two-wire serial bus. It sits between the bus pins and a 256-byte register bank. A fast system clock oversamples the bus clock and data lines. The block recognises the framing conditions and answers only to its own 7-bit device address. It then turns bus traffic into single-cycle write strobes and combinational read fetches on a plain byte-wide bank interface. The data line is driven open-drain: the block only ever pulls it low, through an output-enable.

A host sets an 8-bit register pointer with the first byte after a write-direction address. Any further bytes in the same transfer go to consecutive locations. Reads return bytes from the pointer, one after another, for as long as the host acknowledges them. The pointer survives STOP and repeated START. Between accesses it always holds one past the last location touched, so a read issued with no pointer write continues where the previous access stopped. The pointer wraps from FFh to 00h in both directions.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, `sda_oe` and `reg_we` are 0 and `reg_addr` is 00h.
- R2: An address byte whose upper seven bits equal `DEV_ADDR` (default 69h) is acknowledged. Any other address gets no acknowledge, and the bytes after it in that transfer get no acknowledge and cause no write.
- R3: In a write transfer the first data byte loads the pointer. Each later byte produces one `reg_we` pulse, exactly one clock wide, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then advances by one.
- R4: The target acknowledges every byte it accepts by holding SDA low while SCL is high in the ninth clock of that byte.
- R5: The pointer advances from FFh to 00h, both in burst writes and in burst reads.
- R6: A read transfer that has no pointer write before it returns the byte at the current pointer, which is one past the last location written or read.
- R7: A write transfer that carries only the pointer byte, followed by a repeated START and a read-direction address, returns data from the new pointer and writes nothing.
- R8: Read bytes are sent MSB first. A host acknowledge (SDA low in the ninth clock) makes the target send the byte at the next location. A host non-acknowledge ends the read, and the pointer is then one past the last byte sent.
- R9: A START or STOP that arrives before a byte is complete discards that byte without a write and leaves the pointer unchanged.
- R10: `sda_oe` is asserted only while the synchronized SCL is low, and it is 0 throughout the host's acknowledge slot after a read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| reg_we | output | 1 | Single-cycle write strobe to the register bank |
| reg_addr | output | 8 | Bank location, equal to the register pointer |
| reg_wdata | output | 8 | Byte to store when `reg_we` is high |
| reg_rdata | input | 8 | Combinational bank output for `reg_addr` |

## Verification
The bench aims at the pointer's boundary behaviour. Bursts cross FFh in both directions: a design that carries into a ninth bit or stops at FFh would return or store the wrong bytes once the pointer passes 00h. Transfers are aborted by STOP and by repeated START in the middle of a byte. A design that commits partial bytes, or that advances the pointer on an aborted byte, shows up either as a stray write in the final sweep of the whole bank or as a wrong byte on the next current-address read. A foreign address followed by data checks that a target which acknowledged the wrong address, or which kept decoding after it, would be seen to acknowledge or store those bytes.

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_PTR, ST_WR, ST_RD} st_t;

  st_t        state;
  logic [2:0] scl_p, sda_p;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx, ptr, wdata;
  logic       rw, mack;

  wire scl_s    = scl_p[1];
  wire sda_s    = sda_p[1];
  wire scl_rise = scl_s & ~scl_p[2];
  wire scl_fall = ~scl_s & scl_p[2];
  wire start_c  = scl_s & scl_p[2] & sda_p[2] & ~sda_s;
  wire stop_c   = scl_s & scl_p[2] & ~sda_p[2] & sda_s;

  assign reg_addr  = ptr;
  assign reg_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p  <= 3'b111;
      sda_p  <= 3'b111;
      state  <= ST_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      tx     <= '0;
      ptr    <= '0;
      wdata  <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      reg_we <= 1'b0;
    end else begin
      scl_p  <= {scl_p[1:0], scl_i};
      sda_p  <= {sda_p[1:0], sda_i};
      reg_we <= 1'b0;
      if (reg_we) ptr <= ptr + 8'd1;
      if (start_c) begin
        state  <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        state  <= ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (state != ST_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8)  shreg  <= {shreg[6:0], sda_s};
          if (bitcnt == 4'd8) mack   <= ~sda_s;
          if (bitcnt != 4'd9) bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            case (state)
              ST_DEV: if (shreg[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        rw     <= shreg[0];
                      end else begin
                        state  <= ST_IDLE;
                      end
              ST_PTR: begin ptr <= shreg; sda_oe <= 1'b1; end
              ST_WR:  begin reg_we <= 1'b1; wdata <= shreg; sda_oe <= 1'b1; end
              default: sda_oe <= 1'b0;
            endcase
          end else if (bitcnt == 4'd9) begin
            bitcnt <= '0;
            if ((state == ST_DEV && rw) || (state == ST_RD && mack)) begin
              state  <= ST_RD;
              tx     <= reg_rdata;
              ptr    <= ptr + 8'd1;
              sda_oe <= ~reg_rdata[7];
            end else begin
              sda_oe <= 1'b0;
              case (state)
                ST_DEV:  state <= ST_PTR;
                ST_PTR:  state <= ST_WR;
                ST_RD:   state <= ST_IDLE;
                default: state <= state;
              endcase
            end
          end else if (state == ST_RD) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end

  AST_WE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we); // R3
  AST_PTR_STEP:   assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> reg_addr == $past(reg_addr) + 8'd1); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE) |-> !reg_we); // R2
  AST_DRIVE_LOW:  assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_s); // R10
endmodule

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [7:0] WADDR = 8'hD2;
  localparam logic [7:0] RADDR = 8'hD3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] expm [256];
  logic [7:0] exp_ptr;
  int checks = 0, errors = 0, wcount = 0;
  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target i_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin mem[reg_addr] <= reg_wdata; wcount <= wcount + 1; end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic tick; repeat (Q) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; tick; scl = 1'b1; tick; sda_m = 1'b0; tick; scl = 1'b0; tick;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; tick; scl = 1'b1; tick; sda_m = 1'b1; tick;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick; scl = 1'b1; tick; tick; scl = 1'b0; tick;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick; scl = 1'b1; tick; ack = ~sda_line; tick; scl = 1'b0; tick;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick; scl = 1'b1; tick; d[i] = sda_line; tick; scl = 1'b0; tick;
    end
    sda_m = ~mack; tick; scl = 1'b1; tick;
    chk("R10 released in host ack slot", sda_oe, 0);
    tick; scl = 1'b0; tick;
  endtask

  task automatic read_burst(input int n, input string req);
    logic ack; logic [7:0] d;
    i2c_start;
    send_byte(RADDR, ack); chk("R4 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      chk(req, d, expm[exp_ptr]);
      exp_ptr = exp_ptr + 8'd1;
    end
    i2c_stop;
  endtask

  task automatic write_burst(input logic [7:0] p, input int n, input logic [7:0] seed);
    logic ack;
    i2c_start;
    send_byte(WADDR, ack); chk("R2 own address ack", ack, 1);
    send_byte(p, ack);     chk("R4 pointer byte ack", ack, 1);
    exp_ptr = p;
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = seed + 8'(k * 13);
      send_byte(v, ack); chk("R4 data byte ack", ack, 1);
      expm[exp_ptr] = v;
      exp_ptr = exp_ptr + 8'd1;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack; logic [7:0] d; int w0, bad;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 37 + 11); expm[i] = 8'(i * 37 + 11); end
    exp_ptr = 8'h00;
    repeat (4) @(negedge clk);
    chk("R1 sda_oe", sda_oe, 0); chk("R1 reg_we", reg_we, 0); chk("R1 reg_addr", reg_addr, 0);
    rst_n = 1'b1; tick;

    read_burst(1, "R6 read at reset pointer");

    for (int k = 0; k < 12; k++) begin
      w0 = wcount;
      write_burst(8'(k * 21 + 5), 1, 8'(k * 9 + 8'h40));
      chk("R3 one strobe per byte", wcount - w0, 1);
      chk("R3 pointer after write", reg_addr, exp_ptr);
    end

    w0 = wcount;
    write_burst(8'hFC, 8, 8'hA5);
    chk("R5 write burst wraps", reg_addr, 8'h04);
    chk("R3 burst strobes", wcount - w0, 8);
    read_burst(2, "R6 current-address read");

    w0 = wcount;
    i2c_start;
    send_byte(WADDR, ack); chk("R7 address ack", ack, 1);
    send_byte(8'hFA, ack); chk("R7 pointer ack", ack, 1);
    exp_ptr = 8'hFA;
    read_burst(12, "R8 R5 sequential read across FFh");
    chk("R7 no write during random read", wcount - w0, 0);
    chk("R8 pointer after NACK", reg_addr, 8'h06);

    w0 = wcount;
    i2c_start;
    send_byte(8'h74, ack); chk("R2 foreign address no ack", ack, 0);
    send_byte(8'h06, ack); chk("R2 later byte no ack", ack, 0);
    send_byte(8'h99, ack); chk("R2 later byte no ack", ack, 0);
    i2c_stop;
    chk("R2 no write after foreign address", wcount - w0, 0);
    read_burst(1, "R2 pointer untouched");

    w0 = wcount;
    i2c_start;
    send_byte(WADDR, ack); send_byte(8'h80, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    i2c_stop;
    chk("R9 STOP mid-byte no write", wcount - w0, 0);
    exp_ptr = 8'h80;
    read_burst(1, "R9 pointer kept after STOP abort");

    w0 = wcount;
    i2c_start;
    send_byte(WADDR, ack); send_byte(8'h90, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    exp_ptr = 8'h90;
    read_burst(1, "R9 repeated START keeps pointer");
    chk("R9 START mid-byte no write", wcount - w0, 0);

    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
    chk("R3 R9 bank contents", bad, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule